// File: doc/BRIEF.md
# Compound Adder with Late Increment

This block adds two unsigned operands and delivers two results at once: the plain sum A+B and the incremented sum A+B+1. Both come from a single parallel-prefix carry network, not from two adders. Input cells turn each operand bit pair into three bit signals: generate, propagate and not-kill. A Ladner-Fischer tree then merges these into group generate and group not-kill signals for every prefix span [i:0].

Every cell of the tree is a black cell, including those on the final level. Each bit position therefore receives a group generate and a group not-kill flag. The plain sum uses only the generate term. The incremented sum also flips every bit whose lower bits all transmit a carry.

A late select input, arriving after the operands, chooses which of the two results drives the main sum and carry outputs. Both results also leave the block on their own ports. A typical use is a rounding step that decides late whether to add one. The block is purely combinational. Its width is a power-of-two parameter, 16 by default.

Top module: `fpa_compound_adder`

## Requirements
- R1: `sum_plain_o` with `cout_plain_o` as bit W equals a_i + b_i taken as unsigned W-bit values.
- R2: `sum_inc_o` with `cout_inc_o` as bit W equals a_i + b_i + 1, so the incremented pair is always the plain pair plus one.
- R3: With `inc_i` = 0, `sum_o` and `cout_o` equal `sum_plain_o` and `cout_plain_o`.
- R4: With `inc_i` = 1, `sum_o` and `cout_o` equal `sum_inc_o` and `cout_inc_o`.
- R5: When every bit pair propagates (a_i XOR b_i all ones), the plain result is all ones with carry 0, and the incremented result is all zeros with carry 1. The increment ripples across the full width.
- R6: When both operands are all ones, the plain result is all ones except bit 0 (which is 0), and the incremented result is all ones. Both carries are 1.
- R7: With both operands zero, the plain result is 0 with carry 0, and the incremented result is 1 with carry 0. Bit 0 of the incremented sum is the inverse of that bit's propagate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | first operand |
| b_i | input | W | second operand |
| inc_i | input | 1 | late select: 1 picks A+B+1, 0 picks A+B |
| sum_o | output | W | selected sum |
| cout_o | output | 1 | selected carry out |
| sum_plain_o | output | W | A+B |
| cout_plain_o | output | 1 | carry out of A+B |
| sum_inc_o | output | W | A+B+1 |
| cout_inc_o | output | 1 | carry out of A+B+1 |

## Verification
The bench builds two instances. The first uses W = 8, which makes a full sweep of every operand pair with both select values affordable. That sweep covers every carry chain length, every all-propagate pattern and every wrap-around for the whole three-level tree. The second uses the default W = 16. It is driven with the full-width corner operands (all propagate, all ones, zero) and a stream of pseudo-random pairs. These confirm that the four-level tree at the default width merges the same way.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Index of the lower neighbour a Ladner-Fischer node at bit i merges
    // with on level l: the top bit of the previous aligned block.
    function automatic int lf_partner(input int i, input int l);
        return ((i >> (l + 1)) << (l + 1)) + (1 << l) - 1;
    endfunction

    // True when bit i owns a merge on level l.
    function automatic bit lf_active(input int i, input int l);
        return ((i >> l) & 1) == 1;
    endfunction

endpackage

// File: rtl/fpa_bit_cells.sv
module fpa_bit_cells #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o,
    output logic [W-1:0] nkill_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen_o[i]   = a_i[i] & b_i[i];
        assign prop_o[i]  = a_i[i] ^ b_i[i];
        assign nkill_o[i] = a_i[i] | b_i[i];
    end

endmodule

// File: rtl/fpa_black_cell.sv
module fpa_black_cell (
    input  logic gen_hi_i,
    input  logic nk_hi_i,
    input  logic gen_lo_i,
    input  logic nk_lo_i,
    output logic gen_o,
    output logic nk_o
);

    assign gen_o = gen_hi_i | (nk_hi_i & gen_lo_i);
    assign nk_o  = nk_hi_i & nk_lo_i;

endmodule

// File: rtl/fpa_prefix_tree.sv
module fpa_prefix_tree
    import fpa_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] nk_i,
    output logic [W-1:0] grp_gen_o,
    output logic [W-1:0] grp_nk_o
);

    localparam int LVL = $clog2(W);

    logic [W-1:0] gen_lv [LVL+1];
    logic [W-1:0] nk_lv  [LVL+1];

    assign gen_lv[0] = gen_i;
    assign nk_lv[0]  = nk_i;

    for (genvar l = 0; l < LVL; l++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_node
            if (lf_active(i, l)) begin : g_merge
                localparam int J = lf_partner(i, l);
                fpa_black_cell u_cell (
                    .gen_hi_i (gen_lv[l][i]),
                    .nk_hi_i  (nk_lv[l][i]),
                    .gen_lo_i (gen_lv[l][J]),
                    .nk_lo_i  (nk_lv[l][J]),
                    .gen_o    (gen_lv[l+1][i]),
                    .nk_o     (nk_lv[l+1][i])
                );
            end else begin : g_pass
                assign gen_lv[l+1][i] = gen_lv[l][i];
                assign nk_lv[l+1][i]  = nk_lv[l][i];
            end
        end
    end

    assign grp_gen_o = gen_lv[LVL];
    assign grp_nk_o  = nk_lv[LVL];

endmodule

// File: rtl/fpa_sum_cells.sv
module fpa_sum_cells #(
    parameter int W = 16
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] grp_gen_i,
    input  logic [W-1:0] grp_nk_i,
    output logic [W-1:0] sum0_o,
    output logic [W-1:0] sum1_o,
    output logic         cout0_o,
    output logic         cout1_o
);

    logic [W-1:0] cin0;
    logic [W-1:0] cin1;

    // carry into bit i comes from span [i-1:0]; bit 0 sees the forced carry
    assign cin0 = {grp_gen_i[W-2:0], 1'b0};
    assign cin1 = {grp_gen_i[W-2:0] | grp_nk_i[W-2:0], 1'b1};

    assign sum0_o  = prop_i ^ cin0;
    assign sum1_o  = prop_i ^ cin1;
    assign cout0_o = grp_gen_i[W-1];
    assign cout1_o = grp_gen_i[W-1] | grp_nk_i[W-1];

endmodule

// File: rtl/fpa_compound_adder.sv
module fpa_compound_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inc_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic [W-1:0] sum_plain_o,
    output logic         cout_plain_o,
    output logic [W-1:0] sum_inc_o,
    output logic         cout_inc_o
);

    logic [W-1:0] gen_d;
    logic [W-1:0] prop_d;
    logic [W-1:0] nk_d;
    logic [W-1:0] grp_gen_d;
    logic [W-1:0] grp_nk_d;

    fpa_bit_cells #(.W(W)) u_cells (
        .a_i     (a_i),
        .b_i     (b_i),
        .gen_o   (gen_d),
        .prop_o  (prop_d),
        .nkill_o (nk_d)
    );

    fpa_prefix_tree #(.W(W)) u_tree (
        .gen_i     (gen_d),
        .nk_i      (nk_d),
        .grp_gen_o (grp_gen_d),
        .grp_nk_o  (grp_nk_d)
    );

    fpa_sum_cells #(.W(W)) u_sum (
        .prop_i    (prop_d),
        .grp_gen_i (grp_gen_d),
        .grp_nk_i  (grp_nk_d),
        .sum0_o    (sum_plain_o),
        .sum1_o    (sum_inc_o),
        .cout0_o   (cout_plain_o),
        .cout1_o   (cout_inc_o)
    );

    always_comb begin
        sum_o  = inc_i ? sum_inc_o  : sum_plain_o;
        cout_o = inc_i ? cout_inc_o : cout_plain_o;
    end

endmodule

// File: rtl/fpa_compound_adder_chk.sv
module fpa_compound_adder_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         inc_i,
    input logic [W-1:0] sum_o,
    input logic         cout_o,
    input logic [W-1:0] sum_plain_o,
    input logic         cout_plain_o,
    input logic [W-1:0] sum_inc_o,
    input logic         cout_inc_o
);

    logic [W:0] plain_w;
    logic [W:0] inc_w;
    logic       known;

    always_comb begin
        plain_w = {cout_plain_o, sum_plain_o};
        inc_w   = {cout_inc_o, sum_inc_o};
        known   = !$isunknown({a_i, b_i, inc_i, sum_o, cout_o, plain_w, inc_w});
        if (known) begin
            p_plain_sum_r1: assert (plain_w == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("plain result differs from operand sum");
            p_inc_follows_r2: assert (inc_w == plain_w + 1'b1)
                else $error("incremented result is not plain plus one");
            p_carry_order_r2: assert (!cout_plain_o || cout_inc_o)
                else $error("plain carry without incremented carry");
            p_sel_plain_r3: assert (inc_i || (sum_o == sum_plain_o && cout_o == cout_plain_o))
                else $error("select low does not pass plain result");
            p_sel_inc_r4: assert (!inc_i || (sum_o == sum_inc_o && cout_o == cout_inc_o))
                else $error("select high does not pass incremented result");
            p_full_ripple_r5: assert (((a_i ^ b_i) != '1) || (sum_inc_o == '0 && cout_inc_o))
                else $error("all-propagate increment did not wrap");
        end
    end

endmodule

bind fpa_compound_adder fpa_compound_adder_chk #(.W(W)) u_chk (.*);

// File: tb/fpa_compound_adder_tb.sv
module fpa_compound_adder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WN = 8;
    localparam int WW = 16;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [WN-1:0] a8, b8, s8, sp8, si8;
    logic          inc8, c8, cp8, ci8;
    logic [WW-1:0] a16, b16, s16, sp16, si16;
    logic          inc16, c16, cp16, ci16;

    fpa_compound_adder #(.W(WN)) u_dut (
        .a_i (a8), .b_i (b8), .inc_i (inc8),
        .sum_o (s8), .cout_o (c8),
        .sum_plain_o (sp8), .cout_plain_o (cp8),
        .sum_inc_o (si8), .cout_inc_o (ci8)
    );

    fpa_compound_adder #(.W(WW)) u_wide (
        .a_i (a16), .b_i (b16), .inc_i (inc16),
        .sum_o (s16), .cout_o (c16),
        .sum_plain_o (sp16), .cout_plain_o (cp16),
        .sum_inc_o (si16), .cout_inc_o (ci16)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // all four results of the wide instance for one operand pair
    task automatic wide_case(input string req, input logic [WW-1:0] a, input logic [WW-1:0] b);
        logic [WW:0] ep, ei;
        ep = {1'b0, a} + {1'b0, b};
        ei = ep + 1'b1;
        a16 = a; b16 = b; inc16 = 1'b0;
        #1;
        check({req, " plain R1"}, {cp16, sp16}, ep);
        check({req, " inc R2"},   {ci16, si16}, ei);
        check({req, " sel0 R3"},  {c16, s16},   ep);
        inc16 = 1'b1;
        #1;
        check({req, " sel1 R4"},  {c16, s16},   ei);
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [WN:0] ep, ei;
        a8 = '0; b8 = '0; inc8 = 1'b0;
        a16 = '0; b16 = '0; inc16 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // zero operands right after reset (R7)
        check("R7 plain zero", {cp8, sp8}, 0);
        check("R7 inc zero",   {ci8, si8}, 1);
        check("R7 wide plain zero", {cp16, sp16}, 0);
        check("R7 wide inc zero",   {ci16, si16}, 1);

        // exhaustive sweep of the narrow instance
        for (int a = 0; a < (1 << WN); a++) begin
            for (int b = 0; b < (1 << WN); b++) begin
                ep = WN'(a) + WN'(b) + (WN+1)'(0);
                ep = (WN+1)'(a + b);
                ei = (WN+1)'(a + b + 1);
                a8 = WN'(a); b8 = WN'(b); inc8 = 1'b0;
                #1;
                check("R1 plain", {cp8, sp8}, ep);
                check("R2 inc",   {ci8, si8}, ei);
                check("R3 sel0",  {c8, s8},   ep);
                if ((a ^ b) == (1 << WN) - 1) begin
                    check("R5 prop plain", {cp8, sp8}, {1'b0, {WN{1'b1}}});
                    check("R5 prop inc",   {ci8, si8}, {1'b1, {WN{1'b0}}});
                end
                inc8 = 1'b1;
                #1;
                check("R4 sel1", {c8, s8}, ei);
            end
        end

        // all-ones operands (R6)
        a8 = '1; b8 = '1; inc8 = 1'b0;
        #1;
        check("R6 plain ones", {cp8, sp8}, {1'b1, {(WN-1){1'b1}}, 1'b0});
        check("R6 inc ones",   {ci8, si8}, {1'b1, {WN{1'b1}}});

        // wide instance corners
        wide_case("R5 wide prop", 16'hFFFF, 16'h0000);
        check("R5 wide prop inc", {ci16, si16}, {1'b1, 16'h0000});
        wide_case("R5 wide alt", 16'hAAAA, 16'h5555);
        check("R5 wide alt plain", {cp16, sp16}, {1'b0, 16'hFFFF});
        wide_case("R6 wide ones", 16'hFFFF, 16'hFFFF);
        check("R6 wide plain ones", {cp16, sp16}, {1'b1, 16'hFFFE});
        check("R6 wide inc ones",   {ci16, si16}, {1'b1, 16'hFFFF});
        wide_case("R7 wide zero", 16'h0000, 16'h0000);
        check("R7 wide inc one", {ci16, si16}, {1'b0, 16'h0001});
        wide_case("R1 wide half", 16'h7FFF, 16'h0001);
        wide_case("R2 wide near", 16'h8000, 16'h7FFF);

        lfsr = 16'hACE1;
        for (int k = 0; k < 2000; k++) begin
            logic [WW-1:0] ra;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wide_case("R1 wide rand", ra, lfsr);
        end

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule